// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the configuration word for a frequency synthesizer's dividers. The word has three parts: a 9-bit feedback divide value, a 2-bit output-divide code and a 3-bit test-select field. The word can arrive in two ways. One is a set of parallel pins with a level-sensitive load control. The other is a three-wire serial port with a data line, a shift clock and a transfer strobe. Both paths write the same output register, which drives the divider logic without interruption.

All inputs are asynchronous to the system clock. Each input passes through a chain of synchronising flops, and one more flop stage detects edges on the serial clock and on the strobe. The data lines go through the same chain as the controls, so a data value that is set up a few system cycles before its strobe arrives in step with that strobe. In parallel mode, the outputs follow the pins and the test field reads zero. When the load control returns high, the last pin values stay in place. In serial mode, a 14-bit frame shifts into an internal register. A rising strobe transfers that register to the outputs, and a falling strobe freezes them. The bit that drops off the far end of the shift register is brought out for test readout.

Top module: `divcfg_loader`

## Requirements
- R1: During synchronous reset and afterwards, until a load occurs: the divide value reads all ones (0x1FF), the output code reads 2'b11, the test field reads 3'b000, and shift_out reads 0. The shift register also clears to all zeros.
- R2: While pin_load_n is low, m_out and n_out follow pin_m and pin_n a few system cycles after they change, and t_out reads 3'b000.
- R3: After pin_load_n rises, the outputs keep the pin values present just before the edge. Later changes on pin_m and pin_n have no effect.
- R4: While pin_load_n is high, each rising edge of ser_clk shifts ser_data into bit 0 of a 14-bit register, and the other bits move up one place. A frame is sent T2 first and M0 last. After a frame, bits [13:11] hold T, bits [10:9] hold N and bits [8:0] hold M.
- R5: A rising edge of ser_load while pin_load_n is high copies the shift register to the outputs: t_out = [13:11], n_out = [10:9], m_out = [8:0].
- R6: shift_out holds the bit that the most recent shift pushed out of register bit 13.
- R7: After ser_load falls, the outputs hold their values while further frames are shifted in and the parallel pins change. They hold until the next rising edge of ser_load or until pin_load_n goes low.
- R8: While both ser_load and pin_load_n are high, every rising edge of ser_clk also updates the outputs with the newly shifted register contents.
- R9: A serial transfer replaces parallel values that were latched earlier.
- R10: Rising edges of ser_clk while pin_load_n is low do not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_load_n | input | 1 | Parallel load control; low = transparent, rising edge = hold |
| pin_m | input | 9 | Parallel feedback divide value |
| pin_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on rising ser_clk |
| ser_load | input | 1 | Serial transfer strobe |
| m_out | output | 9 | Feedback divide value to divider |
| n_out | output | 2 | Output divide code to divider |
| t_out | output | 3 | Test-select field |
| shift_out | output | 1 | Last bit shifted out of the register |

## Verification
The parallel path is driven with two different pin words while in transparent mode. The pins are then changed after the hold edge, which separates following the pins from holding them. Two serial frames with asymmetric bit patterns are sent. Every field boundary shows a change, so a swapped or shifted field is caught. The frames are loaded with a rising strobe and then frozen with a falling strobe. This exposes the difference between a one-time transfer, transparent pass-through and a hold. Serial clocks sent during parallel mode are checked later: a strobe transfers the shift register as it stands, so any shift that should not have happened shows up in the output.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;

    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 3;
    localparam int FRAME_W = T_W + N_W + M_W;

    // Packed in frame order: test bits on top, M at the bottom (M0 = bit 0)
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c.t = '0;
        c.n = '1;
        c.m = '1;
        return c;
    endfunction

    function automatic cfg_t cfg_from_pins(input logic [M_W-1:0] m,
                                           input logic [N_W-1:0] n);
        cfg_t c;
        c.t = '0;
        c.n = n;
        c.m = m;
        return c;
    endfunction

endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/divcfg_shifter.sv
module divcfg_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] frame_q,
    output logic [W-1:0] frame_nxt,
    output logic         last_out
);

    assign frame_nxt = shift_en ? {frame_q[W-2:0], bit_in} : frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q  <= '0;
            last_out <= 1'b0;
        end else if (shift_en) begin
            frame_q  <= frame_nxt;
            last_out <= frame_q[W-1];
        end
    end

endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pin_load_n,
    input  logic [divcfg_pkg::M_W-1:0] pin_m,
    input  logic [divcfg_pkg::N_W-1:0] pin_n,
    input  logic                       ser_clk,
    input  logic                       ser_data,
    input  logic                       ser_load,
    output logic [divcfg_pkg::M_W-1:0] m_out,
    output logic [divcfg_pkg::N_W-1:0] n_out,
    output logic [divcfg_pkg::T_W-1:0] t_out,
    output logic                       shift_out
);

    localparam int IN_W = 4 + M_W + N_W;
    localparam logic [IN_W-1:0] IN_RST = {1'b1, {(IN_W-1){1'b0}}};

    logic [IN_W-1:0]    raw_in, syn;
    logic               load_n_q, sl_q, sc_q, sd_q;
    logic [M_W-1:0]     pm_q;
    logic [N_W-1:0]     pn_q;
    logic [1:0]         rises;
    logic               sl_rise, sc_rise;
    logic [FRAME_W-1:0] sr_q, sr_nxt;
    cfg_t               cfg_q;

    // Controls and data share one chain so their relative timing is kept
    assign raw_in = {pin_load_n, ser_load, ser_clk, ser_data, pin_n, pin_m};

    divcfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_in),
        .d_out (syn)
    );

    assign {load_n_q, sl_q, sc_q, sd_q, pn_q, pm_q} = syn;

    divcfg_edge #(.W(2), .RST_VAL(2'b00)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({sl_q, sc_q}),
        .rise (rises)
    );

    assign {sl_rise, sc_rise} = rises;

    divcfg_shifter #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (load_n_q & sc_rise),
        .bit_in    (sd_q),
        .frame_q   (sr_q),
        .frame_nxt (sr_nxt),
        .last_out  (shift_out)
    );

    // Parallel level has priority; serial strobe level gates transfers
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_default();
        else if (!load_n_q)
            cfg_q <= cfg_from_pins(pm_q, pn_q);
        else if (sl_q && (sl_rise || sc_rise))
            cfg_q <= cfg_t'(sr_nxt);
    end

    assign m_out = cfg_q.m;
    assign n_out = cfg_q.n;
    assign t_out = cfg_q.t;

endmodule

// File: rtl/divcfg_checker.sv
module divcfg_checker
    import divcfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               load_n_q,
    input logic               sl_q,
    input logic               sl_rise,
    input logic               sc_rise,
    input logic               sd_q,
    input logic [FRAME_W-1:0] sr_q,
    input logic [M_W-1:0]     m_out,
    input logic [N_W-1:0]     n_out,
    input logic [T_W-1:0]     t_out,
    input logic               shift_out
);

    // R1
    rst_default_chk: assert property (@(posedge clk)
        rst |=> (m_out == '1 && n_out == '1 && t_out == '0 && !shift_out));

    // R2
    par_test_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n_q |=> (t_out == '0));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n_q && !sl_rise && !sc_rise) |=> $stable({t_out, n_out, m_out}));

    // R5
    strobe_transfer_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n_q && sl_rise && !sc_rise) |=> ({t_out, n_out, m_out} == $past(sr_q)));

    // R6
    shift_out_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n_q && sc_rise) |=> (shift_out == $past(sr_q[FRAME_W-1])));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n_q && sl_q && sc_rise) |=> (m_out[0] == $past(sd_q)));

    // R10
    no_shift_par_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n_q |=> $stable(sr_q));

endmodule

bind divcfg_loader divcfg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_n_q  (load_n_q),
    .sl_q      (sl_q),
    .sl_rise   (sl_rise),
    .sc_rise   (sc_rise),
    .sd_q      (sd_q),
    .sr_q      (sr_q),
    .m_out     (m_out),
    .n_out     (n_out),
    .t_out     (t_out),
    .shift_out (shift_out)
);

// File: tb/sim_divcfg_loader.sv
module sim_divcfg_loader;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_load_n = 1'b1;
    logic [8:0] pin_m = '0;
    logic [1:0] pin_n = '0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_load = 1'b0;
    logic [8:0] m_out;
    logic [1:0] n_out;
    logic [2:0] t_out;
    logic       shift_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [13:0] exp_sr  = '0;
    logic [13:0] exp_cfg = {3'b000, 2'b11, 9'h1FF};
    logic        exp_so  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    divcfg_loader u0 (
        .clk(clk), .rst(rst), .pin_load_n(pin_load_n), .pin_m(pin_m),
        .pin_n(pin_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .m_out(m_out), .n_out(n_out),
        .t_out(t_out), .shift_out(shift_out)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_cfg(input string req);
        n_tests++;
        if ({t_out, n_out, m_out} !== exp_cfg) begin
            n_fail++;
            $display("FAIL %s: cfg {t,n,m} got %h expected %h", req,
                     {t_out, n_out, m_out}, exp_cfg);
        end
    endtask

    task automatic check_so(input string req);
        n_tests++;
        if (shift_out !== exp_so) begin
            n_fail++;
            $display("FAIL %s: shift_out got %b expected %b", req, shift_out, exp_so);
        end
    endtask

    // data set up two cycles (40 ns) ahead of the clock edge
    task automatic pulse(input logic b);
        ser_data = b;
        cyc(2);
        ser_clk = 1'b1;
        if (pin_load_n) begin
            exp_so = exp_sr[13];
            exp_sr = {exp_sr[12:0], b};
            if (ser_load) exp_cfg = exp_sr;
        end
        cyc(4);
        ser_clk = 1'b0;
        cyc(4);
    endtask

    task automatic send_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) pulse(f[i]);
    endtask

    task automatic strobe_up;
        ser_load = 1'b1;
        if (pin_load_n) exp_cfg = exp_sr;
        cyc(6);
    endtask

    task automatic strobe_down;
        ser_load = 1'b0;
        cyc(6);
    endtask

    task automatic test_reset;
        rst = 1'b1;
        cyc(4);
        check_cfg("R1 during reset");
        rst = 1'b0;
        cyc(6);
        check_cfg("R1 after reset");
        check_so("R1 shift_out");
    endtask

    task automatic test_par_through;
        pin_load_n = 1'b0;
        pin_m = 9'h0C8; pin_n = 2'b00;
        cyc(6);
        exp_cfg = {3'b000, 2'b00, 9'h0C8};
        check_cfg("R2 transparent A");
        pin_m = 9'h15A; pin_n = 2'b10;
        cyc(6);
        exp_cfg = {3'b000, 2'b10, 9'h15A};
        check_cfg("R2 transparent B");
        // R10: shift clocks in parallel mode must not move the register
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        check_so("R10 no shift");
    endtask

    task automatic test_par_latch;
        cyc(2);
        pin_load_n = 1'b1;
        cyc(6);
        pin_m = 9'h033; pin_n = 2'b01;
        cyc(6);
        check_cfg("R3 latched");
        // transfer of an untouched register: all zero unless R10 was violated
        strobe_up;
        check_cfg("R10/R9 transfer after parallel");
        strobe_down;
    endtask

    task automatic test_serial_frame;
        logic [13:0] f1;
        f1 = {3'b101, 2'b01, 9'h0E7};
        send_frame(f1);
        check_cfg("R7 hold during shift");
        check_so("R6 after first frame");
        strobe_up;
        check_cfg("R5 transfer frame 1");
        n_tests++;
        if (t_out !== 3'b101 || n_out !== 2'b01 || m_out !== 9'h0E7) begin
            n_fail++;
            $display("FAIL R4: fields t=%b n=%b m=%h expected 101 01 0e7", t_out, n_out, m_out);
        end
        strobe_down;
    endtask

    task automatic test_latch_and_shift_out;
        logic [13:0] f2;
        f2 = {3'b010, 2'b10, 9'h13C};
        pin_m = 9'h1AA; pin_n = 2'b11;
        send_frame(f2);
        check_cfg("R7 frozen after strobe fall");
        check_so("R6 last pushed bit");
        strobe_up;
        check_cfg("R5 transfer frame 2");
    endtask

    task automatic test_pass_through;
        // ser_load still high here
        pulse(1'b0);
        check_cfg("R8 pass-through bit 0");
        pulse(1'b1);
        check_cfg("R8 pass-through bit 1");
        check_so("R6 during pass-through");
        strobe_down;
        pulse(1'b1);
        check_cfg("R7 hold after fall");
    endtask

    task automatic test_override;
        pin_load_n = 1'b0;
        pin_m = 9'h07D; pin_n = 2'b01;
        cyc(6);
        exp_cfg = {3'b000, 2'b01, 9'h07D};
        check_cfg("R2 parallel after serial");
        pin_load_n = 1'b1;
        cyc(6);
        send_frame({3'b011, 2'b00, 9'h168});
        check_cfg("R3 parallel still held");
        strobe_up;
        check_cfg("R9 serial overrides parallel");
        strobe_down;
    endtask

    initial begin
        test_reset;
        test_par_through;
        test_par_latch;
        test_serial_frame;
        test_latch_and_shift_out;
        test_pass_through;
        test_override;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule